// File: doc/BRIEF.md
# Parallel NOR Flash Identification Sequencer

This block is a host-side bus master that works out which parallel NOR flash sits on an external memory bus. A single-cycle `start` pulse makes it send the three-write autoselect unlock sequence, read the manufacturer word and then the device word, and classify the part. The classification covers the command family (which read-mode reset the part needs), the sector count and the total size in bytes.

The unlock writes are harmless to a family that ignores them, so one probe serves two incompatible command sets. When a part is recognised, the block writes that family's read-mode command to return the array to normal reads. It then pulses `done` and holds its results until the next accepted `start`.

Each access on the bus side is a request/ready handshake. The block raises `bus_req` with the address, write data and direction. The access completes in the first cycle in which `bus_ready` is also high. In a read, `bus_rdata` is sampled in that same cycle. While `bus_ready` is low the block holds every request field unchanged; this is the back-pressure rule. Bus offsets are word offsets that are shifted into byte addresses.

Top module: `nor_id_probe`

## Requirements
- R1: After an accepted `start`, the first three accesses are writes in this order: command 0xAA at word offset 0x555, then 0x55 at offset 0x2AA, then 0x90 at offset 0x555. A byte address is the word offset shifted left by log2(BUS_W/8), which is 2 for the default 32-bit bus.
- R2: Every command byte is placed in bits [7:0] of each 16-bit lane of `bus_wdata`, with bits [15:8] of each lane zero. For example, 0xAA on a 32-bit bus is 0x00AA00AA.
- R3: The fourth access reads word offset 0. Only bits [7:0] of that word are compared. 0x01 gives `vendor`=1, 0x89 gives `vendor`=2, and any other value gives `vendor`=0 with `sectors`=0, `size_bytes`=0 and `dev_code`=0, and no further access.
- R4: For a known vendor, the fifth access reads word offset 1. The whole bus word must equal one 16-bit code repeated in every lane. Codes 0x22DA→19 sectors/1 MiB, 0x22D7→128/8 MiB, 0x88C1 or 0x8893→23/1 MiB, 0x88C3 or 0x8891→39/2 MiB, 0x88C5 or 0x8897→71/4 MiB, 0x88CD or 0x8899→135/8 MiB. The sizes given are for a 16-bit bus.
- R5: A device word that matches no supported code, or whose lanes differ, gives `vendor`=0, `sectors`=0 and `size_bytes`=0. `dev_code` shows the word read, and no further access follows.
- R6: `size_bytes` equals the 16-bit-bus size multiplied by BUS_W/16.
- R7: After a recognised device, one final write to word offset 0 carries 0xF0 for `vendor`=1 or 0xFF for `vendor`=2, replicated as in R2.
- R8: While `bus_req` is high and `bus_ready` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` keep their values into the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the last access completes. The result outputs keep their values from then until the next accepted `start`.
- R10: A `start` pulse during a probe has no effect: the access sequence and the results are those of the probe already running.
- R11: After reset, `bus_req`, `done`, `vendor`, `dev_code`, `sectors` and `size_bytes` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe when idle |
| done | output | 1 | One-cycle completion pulse |
| vendor | output | 2 | 0 unknown, 1 family using 0xF0 reset, 2 family using 0xFF reset |
| dev_code | output | BUS_W | Device word read from offset 1 |
| sectors | output | SEC_W | Sector count of the identified part |
| size_bytes | output | SIZE_W | Total array size in bytes |
| bus_req | output | 1 | Access request (valid) |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_wdata | output | BUS_W | Write data |
| bus_ready | input | 1 | Access accepted this cycle |
| bus_rdata | input | BUS_W | Read data, valid when a read is accepted |

## Verification
Any fault in the sequencer state shows up on the bus within one accepted access. Examples are an extra or missing access, a wrong offset, or a command byte in the wrong lane. The bench records every accepted access and compares the log with the expected order.

A wrong classification shows up at the `done` pulse, in `vendor`, `sectors` or `size_bytes`. It also shows up in whether the final read-mode write appears and which byte it carries. Random wait states stress the hold rule on every access, and a second `start` during a probe must leave both the log and the results unchanged.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNLK1, ST_UNLK2, ST_AUTOSEL,
    ST_RD_MFR, ST_RD_DEV, ST_RD_MODE, ST_DONE
  } probe_st_t;

  typedef enum logic [1:0] {
    FAM_NONE = 2'd0,
    FAM_F0   = 2'd1,
    FAM_FF   = 2'd2
  } fam_t;

  localparam logic [7:0] MFR_CODE_F0 = 8'h01;
  localparam logic [7:0] MFR_CODE_FF = 8'h89;

  function automatic fam_t fam_of(input logic [7:0] b);
    if (b == MFR_CODE_F0)      return FAM_F0;
    else if (b == MFR_CODE_FF) return FAM_FF;
    else                       return FAM_NONE;
  endfunction

endpackage

// File: rtl/nor_probe_cmd.sv
module nor_probe_cmd
  import nor_probe_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 24
) (
  input  probe_st_t          st,
  input  fam_t               fam,
  output logic [ADDR_W-1:0]  addr,
  output logic [BUS_W-1:0]   wdata,
  output logic               we
);
  localparam int LANES = BUS_W / 16;
  localparam int SHIFT = $clog2(BUS_W / 8);
  localparam int OFF_W = 12;

  logic [OFF_W-1:0] off;
  logic [7:0]       cmd;

  always_comb begin
    off = '0;
    cmd = 8'h00;
    we  = 1'b0;
    case (st)
      ST_UNLK1:   begin off = 12'h555; cmd = 8'hAA; we = 1'b1; end
      ST_UNLK2:   begin off = 12'h2AA; cmd = 8'h55; we = 1'b1; end
      ST_AUTOSEL: begin off = 12'h555; cmd = 8'h90; we = 1'b1; end
      ST_RD_MFR:  begin off = 12'h000; end
      ST_RD_DEV:  begin off = 12'h001; end
      ST_RD_MODE: begin
        off = 12'h000;
        cmd = (fam == FAM_FF) ? 8'hFF : 8'hF0;
        we  = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata[g*16 +: 16] = {8'h00, cmd};
  end

  assign addr = {{(ADDR_W-OFF_W){1'b0}}, off} << SHIFT;

endmodule

// File: rtl/nor_probe_dev.sv
module nor_probe_dev #(
  parameter int BUS_W  = 32,
  parameter int SEC_W  = 8,
  parameter int SIZE_W = 32
) (
  input  logic [BUS_W-1:0]  word,
  output logic              hit,
  output logic [SEC_W-1:0]  sectors,
  output logic [SIZE_W-1:0] size_bytes
);
  localparam int LANES = BUS_W / 16;

  logic [LANES-1:0] same;
  logic             hit16;
  logic [3:0]       mib;

  for (genvar g = 0; g < LANES; g++) begin : g_same
    assign same[g] = (word[g*16 +: 16] == word[15:0]);
  end

  always_comb begin
    hit16   = 1'b1;
    sectors = '0;
    mib     = 4'd0;
    case (word[15:0])
      16'h22DA:          begin sectors = SEC_W'(19);  mib = 4'd1; end
      16'h22D7:          begin sectors = SEC_W'(128); mib = 4'd8; end
      16'h88C1, 16'h8893: begin sectors = SEC_W'(23);  mib = 4'd1; end
      16'h88C3, 16'h8891: begin sectors = SEC_W'(39);  mib = 4'd2; end
      16'h88C5, 16'h8897: begin sectors = SEC_W'(71);  mib = 4'd4; end
      16'h88CD, 16'h8899: begin sectors = SEC_W'(135); mib = 4'd8; end
      default:           hit16 = 1'b0;
    endcase
  end

  assign hit        = hit16 && (&same);
  assign size_bytes = (SIZE_W'(mib) * SIZE_W'(LANES)) << 20;

endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
  import nor_probe_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 24,
  parameter int SEC_W  = 8,
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic [1:0]        vendor,
  output logic [BUS_W-1:0]  dev_code,
  output logic [SEC_W-1:0]  sectors,
  output logic [SIZE_W-1:0] size_bytes,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_ready,
  input  logic [BUS_W-1:0]  bus_rdata
);
  probe_st_t         st;
  fam_t              fam_q;
  fam_t              rd_fam;
  logic              acc;
  logic              dev_hit;
  logic [SEC_W-1:0]  dev_sec;
  logic [SIZE_W-1:0] dev_size;

  nor_probe_cmd #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_cmd (
    .st(st), .fam(fam_q), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we)
  );

  nor_probe_dev #(.BUS_W(BUS_W), .SEC_W(SEC_W), .SIZE_W(SIZE_W)) u_dev (
    .word(bus_rdata), .hit(dev_hit), .sectors(dev_sec), .size_bytes(dev_size)
  );

  assign bus_req = (st != ST_IDLE) && (st != ST_DONE);
  assign acc     = bus_req && bus_ready;
  assign rd_fam  = fam_of(bus_rdata[7:0]);
  assign done    = (st == ST_DONE);
  assign vendor  = fam_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      fam_q      <= FAM_NONE;
      dev_code   <= '0;
      sectors    <= '0;
      size_bytes <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st         <= ST_UNLK1;
          fam_q      <= FAM_NONE;
          dev_code   <= '0;
          sectors    <= '0;
          size_bytes <= '0;
        end
        ST_UNLK1:   if (acc) st <= ST_UNLK2;
        ST_UNLK2:   if (acc) st <= ST_AUTOSEL;
        ST_AUTOSEL: if (acc) st <= ST_RD_MFR;
        ST_RD_MFR: if (acc) begin
          if (rd_fam == FAM_NONE) st <= ST_DONE;
          else begin
            fam_q <= rd_fam;
            st    <= ST_RD_DEV;
          end
        end
        ST_RD_DEV: if (acc) begin
          dev_code <= bus_rdata;
          if (dev_hit) begin
            sectors    <= dev_sec;
            size_bytes <= dev_size;
            st         <= ST_RD_MODE;
          end else begin
            fam_q <= FAM_NONE;
            st    <= ST_DONE;
          end
        end
        ST_RD_MODE: if (acc) st <= ST_DONE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nor_probe_chk.sv
module nor_probe_chk #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 24,
  parameter int SEC_W  = 8,
  parameter int SIZE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [1:0]        vendor,
  input logic [SEC_W-1:0]  sectors,
  input logic [SIZE_W-1:0] size_bytes,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_ready
);
  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) &&
                              $stable(bus_wdata) && $stable(bus_we));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && !start |=> $stable(vendor) && $stable(sectors) && $stable(size_bytes));

  // R3
  unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && vendor == 2'd0 |-> sectors == '0 && size_bytes == '0);

  // R2
  lane_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_wdata[15:8] == 8'h00 &&
                          bus_wdata[BUS_W-1 -: 16] == bus_wdata[15:0]);

  // R4
  sector_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && vendor != 2'd0 |-> sectors == SEC_W'(19) || sectors == SEC_W'(128) ||
      sectors == SEC_W'(23) || sectors == SEC_W'(39) ||
      sectors == SEC_W'(71) || sectors == SEC_W'(135));

endmodule

bind nor_id_probe nor_probe_chk #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .vendor(vendor),
  .sectors(sectors), .size_bytes(size_bytes), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ready(bus_ready)
);

// File: tb/sim_nor_id_probe.sv
module sim_nor_id_probe;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 24;
  localparam int SEC_W  = 8;
  localparam int SIZE_W = 32;
  localparam int SHIFT  = 2;
  localparam int LOG_N  = 256;

  logic clk = 0, rst_n = 0, start = 0;
  logic done, bus_req, bus_we, bus_ready = 0;
  logic [1:0] vendor;
  logic [BUS_W-1:0] dev_code, bus_wdata, bus_rdata;
  logic [SEC_W-1:0] sectors;
  logic [SIZE_W-1:0] size_bytes;
  logic [ADDR_W-1:0] bus_addr;

  logic [BUS_W-1:0] mfr_word = '0, dev_word = '0;
  int ready_pct = 100;
  int n_total = 0;
  logic [ADDR_W-1:0] log_addr [LOG_N];
  logic [BUS_W-1:0]  log_data [LOG_N];
  logic              log_we   [LOG_N];
  int errors = 0, checks = 0;

  nor_id_probe #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W), .SIZE_W(SIZE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .vendor(vendor),
    .dev_code(dev_code), .sectors(sectors), .size_bytes(size_bytes),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    if (bus_addr == '0)                            bus_rdata = mfr_word;
    else if (bus_addr == ADDR_W'(1 << SHIFT))      bus_rdata = dev_word;
    else                                           bus_rdata = 32'hDEAD_BEEF;
  end

  always @(posedge clk) begin
    if (bus_req && bus_ready) begin
      log_addr[n_total % LOG_N] <= bus_addr;
      log_data[n_total % LOG_N] <= bus_wdata;
      log_we[n_total % LOG_N]   <= bus_we;
      n_total <= n_total + 1;
    end
  end

  always @(negedge clk) bus_ready <= ($urandom_range(99) < ready_pct);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] rep(input logic [15:0] c);
    return {c, c};
  endfunction

  function automatic int exp_fam(input logic [BUS_W-1:0] m);
    if (m[7:0] == 8'h01) return 1;
    if (m[7:0] == 8'h89) return 2;
    return 0;
  endfunction

  function automatic int exp_sec(input logic [BUS_W-1:0] d);
    if (d[31:16] != d[15:0]) return 0;
    case (d[15:0])
      16'h22DA: return 19;
      16'h22D7: return 128;
      16'h88C1, 16'h8893: return 23;
      16'h88C3, 16'h8891: return 39;
      16'h88C5, 16'h8897: return 71;
      16'h88CD, 16'h8899: return 135;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_mib16(input int s);
    case (s)
      19, 23: return 1;
      39: return 2;
      71: return 4;
      128, 135: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic chk_entry(input int idx, input logic we, input logic [11:0] off,
                           input logic [7:0] cmd, input string tag);
    int k = idx % LOG_N;
    chk(log_we[k] == we, {tag, " dir"}, 64'(log_we[k]), 64'(we));
    chk(log_addr[k] == (ADDR_W'(off) << SHIFT), {tag, " addr"}, 64'(log_addr[k]),
        64'(ADDR_W'(off) << SHIFT));
    if (we) chk(log_data[k] == rep({8'h00, cmd}), {tag, " data"}, 64'(log_data[k]),
                64'(rep({8'h00, cmd})));
  endtask

  task automatic run_probe(input logic [BUS_W-1:0] m, input logic [BUS_W-1:0] d,
                           input bit busy_start);
    int base, fam, sec, n_exp, wd;
    logic [SIZE_W-1:0] sz;
    logic [BUS_W-1:0] dc;
    fam = exp_fam(m);
    sec = (fam != 0) ? exp_sec(d) : 0;
    if (sec == 0 && fam != 0) fam = 0;
    sz = SIZE_W'(exp_mib16(sec)) * SIZE_W'(BUS_W/16) << 20;
    dc = (exp_fam(m) != 0) ? d : '0;
    n_exp = (exp_fam(m) == 0) ? 4 : (sec == 0 ? 5 : 6);
    mfr_word = m; dev_word = d;
    @(negedge clk);
    base = n_total;
    start = 1;
    @(negedge clk) start = 0;
    if (busy_start) begin
      @(negedge clk) start = 1;   // R10: pulse while busy
      @(negedge clk) start = 0;
    end
    wd = 0;
    while (!done && wd < 2000) begin @(negedge clk); wd++; end
    chk(wd < 2000, "watchdog", 64'(wd), 64'(0));
    chk(n_total - base == n_exp, "R10 R3 R5 access count", 64'(n_total - base), 64'(n_exp));
    chk_entry(base,   1'b1, 12'h555, 8'hAA, "R1 R2 unlock1");
    chk_entry(base+1, 1'b1, 12'h2AA, 8'h55, "R1 R2 unlock2");
    chk_entry(base+2, 1'b1, 12'h555, 8'h90, "R1 R2 autoselect");
    chk_entry(base+3, 1'b0, 12'h000, 8'h00, "R3 mfr read");
    if (n_exp >= 5) chk_entry(base+4, 1'b0, 12'h001, 8'h00, "R4 dev read");
    if (n_exp == 6) chk_entry(base+5, 1'b1, 12'h000, (fam == 2) ? 8'hFF : 8'hF0, "R7 read mode");
    chk(vendor == 2'(fam), "R3 R5 vendor", 64'(vendor), 64'(fam));
    chk(sectors == SEC_W'(sec), "R4 R5 sectors", 64'(sectors), 64'(sec));
    chk(size_bytes == sz, "R6 size", 64'(size_bytes), 64'(sz));
    chk(dev_code == dc, "R5 dev_code", 64'(dev_code), 64'(dc));
    @(negedge clk);
    chk(done == 1'b0, "R9 done width", 64'(done), 64'(0));
    repeat (3) @(negedge clk);
    chk(sectors == SEC_W'(sec) && size_bytes == sz && vendor == 2'(fam),
        "R9 results held", 64'(sectors), 64'(sec));
  endtask

  initial begin
    logic [15:0] codes [10] = '{16'h22DA, 16'h22D7, 16'h88C1, 16'h8893, 16'h88C3,
                                16'h8891, 16'h88C5, 16'h8897, 16'h88CD, 16'h8899};
    logic [BUS_W-1:0] m, d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R11
    chk(bus_req == 0 && done == 0, "R11 reset ctl", 64'({bus_req, done}), 64'(0));
    chk(vendor == 0 && sectors == 0 && size_bytes == 0 && dev_code == 0,
        "R11 reset results", 64'(size_bytes), 64'(0));
    rst_n = 1;
    // directed corners
    run_probe(32'h0000_0001, rep(16'h22DA), 1'b0);       // R7 F0 family, R6
    run_probe(32'h0000_0089, rep(16'h88CD), 1'b0);       // R7 FF family
    run_probe(32'hABCD_5501, rep(16'h22D7), 1'b0);       // R3 upper bits ignored
    run_probe(32'h0000_0020, rep(16'h22DA), 1'b0);       // R3 unknown vendor
    run_probe(32'h0000_0089, {16'h88C1, 16'h88C3}, 1'b0); // R5 lanes differ
    run_probe(32'h0000_0089, rep(16'h1234), 1'b0);       // R5 unknown device
    run_probe(32'h0000_0001, rep(16'h8897), 1'b1);       // R10 busy start
    ready_pct = 40;                                      // R8 wait states
    for (int i = 0; i < 24; i++) begin
      int r = $urandom_range(9);
      m = (r < 4) ? {$urandom, 8'h01} : (r < 8) ? {$urandom, 8'h89} : $urandom;
      r = $urandom_range(9);
      d = (r < 7) ? rep(codes[$urandom_range(9)]) : $urandom;
      run_probe(m, d, $urandom_range(1) == 1);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule